// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is a serial-peripheral slave that sits inside the programmable logic and accepts fixed-length command words from a host controller. Each word is sixteen bits long and is sent with the most significant bit first. The top four bits carry a command code and the low twelve bits carry an operand. The host frames every word with its own chip-select assertion and releases chip select after each one.

SCK, MOSI and the active-low chip select arrive from the host without any timing relation to the local system clock. Each one passes through a two-flop synchroniser, and the block finds the SCK and chip-select edges in the system clock domain. The system clock must run at least four times as fast as SCK. A word is decoded only when chip select rises after exactly sixteen sampled bits. A decoded word produces a one-cycle strobe together with its command and operand.

One command code, `CFG_CMD`, writes the low eight bits of its operand into a held mode register. The rest of the logic uses that register to choose its operating mode. A frame with the wrong bit count is dropped and sets a sticky error flag.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, `word_vld` is 0, `frame_err` is 0, `mode_reg` is 0, `cmd` is 0 and `data` is 0.
- R2: MOSI is sampled on each rising SCK edge while `cs_n` is low, most significant bit first. When `cs_n` rises after exactly 16 samples, `word_vld` pulses high for exactly one cycle, `cmd` shows word bits 15..12 and `data` shows word bits 11..0.
- R3: A word whose command code is not `CFG_CMD` still gives the strobe, `cmd` and `data`, and it leaves `mode_reg` unchanged.
- R4: A word with command code `CFG_CMD` (default 4'h1) loads `data[7:0]` into `mode_reg` in the same cycle as its strobe. Operand bits 11..8 are not stored.
- R5: A frame with fewer than 16 sampled bits gives no strobe and leaves `cmd`, `data` and `mode_reg` unchanged. It sets `frame_err`.
- R6: A frame with more than 16 sampled bits is handled the same way as in R5: no strobe, no change to any output, and `frame_err` is set, even when its leading bits form a configuration write.
- R7: `frame_err` stays at 1 until reset. Well-formed frames that follow an error are still decoded normally.
- R8: SCK edges and MOSI activity while `cs_n` is high are ignored. They give no strobe and no error, and they add no bits to the next frame.
- R9: `cmd` and `data` hold their last decoded values until the next valid word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the SCK rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| cs_n | input | 1 | Active-low chip select, one assertion per word |
| word_vld | output | 1 | One-cycle strobe for each decoded word |
| cmd | output | 4 | Command code of the last decoded word |
| data | output | 12 | Operand of the last decoded word |
| mode_reg | output | 8 | Held configuration (mode) register |
| frame_err | output | 1 | Sticky flag for a frame with the wrong bit count |

## Verification
The assertions check on every cycle that the strobe never lasts longer than one cycle, that the error flag never clears, and that `cmd`, `data` and `mode_reg` change only on a strobe. They also check that a configuration write matches the operand it carries. Only the bench scenarios can show that the bit order and the field split are correct, that short and long frames are dropped, and that SCK activity outside a frame adds no bits. Each of these depends on the serial waveform the host drives.

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 12,
  parameter int CFG_W  = 8,
  parameter logic [CMD_W-1:0] CFG_CMD = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              mosi,
  input  logic              cs_n,
  output logic              word_vld,
  output logic [CMD_W-1:0]  cmd,
  output logic [DATA_W-1:0] data,
  output logic [CFG_W-1:0]  mode_reg,
  output logic              frame_err
);
  localparam int WORD_W = CMD_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [2:0] sck_sy, cs_sy;
  logic [1:0] mosi_sy;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;

  wire sck_rise = sck_sy[1] & ~sck_sy[2];
  wire cs_rise  = cs_sy[1] & ~cs_sy[2];
  wire cs_fall  = ~cs_sy[1] & cs_sy[2];
  wire in_frame = ~cs_sy[1];
  wire [CMD_W-1:0] rx_cmd = shreg[WORD_W-1 -: CMD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy  <= '0;
      cs_sy   <= '1;
      mosi_sy <= '0;
    end else begin
      sck_sy  <= {sck_sy[1:0], sck};
      cs_sy   <= {cs_sy[1:0], cs_n};
      mosi_sy <= {mosi_sy[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (in_frame && sck_rise) begin
      shreg <= {shreg[WORD_W-2:0], mosi_sy[1]};
      if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_vld  <= 1'b0;
      cmd       <= '0;
      data      <= '0;
      mode_reg  <= '0;
      frame_err <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (cs_rise) begin
        if (bit_cnt == CNT_FULL) begin
          word_vld <= 1'b1;
          cmd      <= rx_cmd;
          data     <= shreg[DATA_W-1:0];
          if (rx_cmd == CFG_CMD) mode_reg <= shreg[CFG_W-1:0];
        end else begin
          frame_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_cmd_rx_chk.sv
module spi_cmd_rx_chk #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 12,
  parameter int CFG_W  = 8,
  parameter logic [CMD_W-1:0] CFG_CMD = 4'h1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_vld,
  input logic [CMD_W-1:0]  cmd,
  input logic [DATA_W-1:0] data,
  input logic [CFG_W-1:0]  mode_reg,
  input logic              frame_err
);
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  p_mode_only_on_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_reg) |-> (word_vld && cmd == CFG_CMD));

  p_cfg_loaded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && cmd == CFG_CMD) |-> mode_reg == data[CFG_W-1:0]);

  p_err_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !word_vld);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  p_fields_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |-> ($stable(cmd) && $stable(data)));
endmodule

bind spi_cmd_rx spi_cmd_rx_chk #(
  .CMD_W(CMD_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .CFG_CMD(CFG_CMD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .cmd(cmd),
  .data(data), .mode_reg(mode_reg), .frame_err(frame_err)
);

// File: tb/spi_cmd_rx_tb.sv
module spi_cmd_rx_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic cs_n = 1'b1;
  logic word_vld;
  logic [3:0] cmd;
  logic [11:0] data;
  logic [7:0] mode_reg;
  logic frame_err;

  int n_chk = 0;
  int n_bad = 0;
  int pulses;
  logic [3:0] cap_cmd;
  logic [11:0] cap_data;

  always #4 clk = ~clk;

  spi_cmd_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .cs_n(cs_n),
    .word_vld(word_vld), .cmd(cmd), .data(data),
    .mode_reg(mode_reg), .frame_err(frame_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      repeat (5) @(negedge clk);
      sck = 1'b1;
      repeat (5) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    pulses = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (word_vld) begin
        pulses++;
        cap_cmd = cmd;
        cap_data = data;
      end
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 vld", word_vld, 0);
    check("R1 err", frame_err, 0);
    check("R1 mode", mode_reg, 0);
    check("R1 cmd", cmd, 0);
    check("R1 data", data, 0);
  endtask

  task automatic t_plain();
    send(32'h3ABC, 16);
    check("R2 pulses", pulses, 1);
    check("R2 cmd", cap_cmd, 4'h3);
    check("R2 data", cap_data, 12'hABC);
    check("R3 mode unchanged", mode_reg, 0);
    send(32'hF001, 16);
    check("R2 cmd msb", cap_cmd, 4'hF);
    check("R2 data lsb", cap_data, 12'h001);
    repeat (50) @(negedge clk);
    check("R9 cmd hold", cmd, 4'hF);
    check("R9 data hold", data, 12'h001);
  endtask

  task automatic t_cfg();
    send(32'h1F5A, 16);
    check("R4 pulses", pulses, 1);
    check("R4 cmd", cap_cmd, 4'h1);
    check("R4 mode", mode_reg, 8'h5A);
    send(32'h8FFF, 16);
    check("R3 mode kept", mode_reg, 8'h5A);
    check("R3 data", cap_data, 12'hFFF);
  endtask

  task automatic t_short();
    send(32'h155, 10);
    check("R5 pulses", pulses, 0);
    check("R5 err", frame_err, 1);
    check("R5 cmd kept", cmd, 4'h8);
    check("R5 data kept", data, 12'hFFF);
    check("R5 mode kept", mode_reg, 8'h5A);
  endtask

  task automatic t_sticky();
    send(32'h2123, 16);
    check("R7 pulses", pulses, 1);
    check("R7 cmd", cap_cmd, 4'h2);
    check("R7 data", cap_data, 12'h123);
    check("R7 err stays", frame_err, 1);
  endtask

  task automatic t_long();
    do_reset();
    send(32'h1A5C3, 20);
    check("R6 pulses", pulses, 0);
    check("R6 err", frame_err, 1);
    check("R6 mode", mode_reg, 0);
    check("R6 cmd", cmd, 0);
  endtask

  task automatic t_idle_sck();
    do_reset();
    for (int i = 0; i < 8; i++) begin
      mosi = 1'b1;
      repeat (5) @(negedge clk);
      sck = 1'b1;
      repeat (5) @(negedge clk);
      sck = 1'b0;
    end
    mosi = 1'b0;
    repeat (12) @(negedge clk);
    check("R8 no vld", word_vld, 0);
    check("R8 no err", frame_err, 0);
    send(32'h1042, 16);
    check("R8 pulses", pulses, 1);
    check("R8 cmd", cap_cmd, 4'h1);
    check("R8 data", cap_data, 12'h042);
    check("R8 mode", mode_reg, 8'h42);
    check("R8 err", frame_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_cfg();
    t_short();
    t_sticky();
    t_long();
    t_idle_sck();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule